// File: doc/BRIEF.md
# Memory Block Transfer Engine

The engine copies a string of bytes from one region of a byte-wide memory to another. It holds a source pointer, a destination pointer and a byte count, all of the same parameterised width (16 bits by default). Software loads these three registers while the engine is idle, then issues a start command with a three-bit mode: one step or a repeat that runs until the count is exhausted, upward or downward pointer movement, and an optional search that stops when the byte just read equals a delimiter key.

Each byte occupies a fixed slot of clock cycles. In the first cycle of the slot the engine reads the source byte. In the second cycle it writes that byte to the destination and updates the pointers and the count. The rest of the slot is idle padding. This gives a cost per byte that never varies, which a scheduler can rely on. The engine reports a busy level, a flag that tracks whether the count is nonzero after each decrement, and a flag raised by a search hit.

Top module: `blkmv_engine`

## Requirements
- R1: One byte step drives a read of the source address (mem_rd high), and in the next cycle writes the returned byte (mem_rdata, valid the cycle after mem_rd) to the destination address (mem_wr high). The step then moves both pointers by one and lowers the count by one. Read and write never happen in the same cycle.
- R2: The mode field is decoded as bit 2 = repeat, bit 1 = decrement, bit 0 = search. With the repeat bit clear, exactly one byte is moved. With it set, steps continue until the count reaches zero.
- R3: Every byte slot lasts REPEAT_CYCLES clocks (default 21) in repeat mode and STEP_CYCLES clocks (default 16) in single mode. Busy is high for exactly slots × cost cycles.
- R4: With the decrement bit set, both pointers move downward by one per byte instead of upward.
- R5: After every decrement, cnt_nz becomes 0 if the new count is zero and 1 otherwise. No other event changes it.
- R6: A repeat start with a count of zero moves 2^ADDR_W bytes, because the count wraps.
- R7: Both pointers wrap modulo 2^ADDR_W in either direction.
- R8: In search mode, a source byte equal to key is not written, and the pointers and the count keep their values. The match flag is set and the run ends after that slot. Every accepted start clears match.
- R9: Busy rises the cycle after an accepted start and stays high until the last slot ends. While busy is high, start and all register loads are ignored. While busy is low, no memory access happens.
- R10: After reset, busy, cnt_nz, match, mem_rd and mem_wr are 0, and all registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command, taken only when idle |
| mode | input | 3 | {repeat, decrement, search} |
| key | input | 8 | Delimiter byte compared in search mode, held stable during a run |
| ld_src | input | 1 | Load source pointer from ld_val |
| ld_dst | input | 1 | Load destination pointer from ld_val |
| ld_cnt | input | 1 | Load byte count from ld_val |
| ld_val | input | ADDR_W | Load value |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, registered by the memory |
| busy | output | 1 | Transfer in progress |
| cnt_nz | output | 1 | Count was nonzero after the last decrement |
| match | output | 1 | Search hit occurred in the current or last run |

## Verification
A pointer that is off by one, or that moves the wrong way, shows up in memory contents as soon as the first written byte lands at the wrong address. The bench compares the whole memory image after every run, and it chains runs without reloading, so stale or corrupted pointer state is exposed by the next run. A wrong count or stop decision shows in the busy length within one slot of the expected end, and the busy length is compared against slots × cost. Flags are sampled at the end of each run, so a wrong update of cnt_nz or match is seen one run later at most.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    typedef struct packed {
        logic rpt;   // bit 2
        logic dec;   // bit 1
        logic srch;  // bit 0
    } xfer_mode_t;

    localparam int PTR_SRC = 0;
    localparam int PTR_DST = 1;
    localparam int NUM_PTR = 2;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/blkmv_regs.sv
module blkmv_regs
    import blkmv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [NUM_PTR-1:0] ld_ptr,
    input  logic         ld_cnt,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic         dec,
    output logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic         cnt_nz,
    output logic         last
);
    logic [W-1:0] ptr_q [NUM_PTR];
    logic [W-1:0] cnt_q;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[g] <= '0;
            end else if (ld_en && ld_ptr[g]) begin
                ptr_q[g] <= ld_val;
            end else if (adv) begin
                ptr_q[g] <= dec ? (ptr_q[g] - W'(1)) : (ptr_q[g] + W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cnt_nz <= 1'b0;
        end else if (ld_en && ld_cnt) begin
            cnt_q <= ld_val;
        end else if (adv) begin
            cnt_q  <= cnt_q - W'(1);
            cnt_nz <= !last;
        end
    end

    assign last = (cnt_q == W'(1));
    assign src  = ptr_q[PTR_SRC];
    assign dst  = ptr_q[PTR_DST];

endmodule

// File: rtl/blkmv_seq.sv
module blkmv_seq
    import blkmv_pkg::*;
#(
    parameter int STEP_CYCLES   = 16,
    parameter int REPEAT_CYCLES = 21
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_acc,
    input  xfer_mode_t mode_in,
    input  logic       hit,
    input  logic       last,
    output logic       busy,
    output logic       rd_phase,
    output logic       wr_phase,
    output xfer_mode_t mode_q
);
    localparam int MAXC = max_int(STEP_CYCLES, REPEAT_CYCLES);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] slot_q;
    logic [CW-1:0] end_slot;
    logic          stop_q;

    assign end_slot = mode_q.rpt ? CW'(REPEAT_CYCLES - 1) : CW'(STEP_CYCLES - 1);
    assign rd_phase = busy && (slot_q == CW'(0));
    assign wr_phase = busy && (slot_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            slot_q <= '0;
            stop_q <= 1'b0;
            mode_q <= '0;
        end else if (!busy) begin
            if (start_acc) begin
                busy   <= 1'b1;
                slot_q <= '0;
                stop_q <= 1'b0;
                mode_q <= mode_in;
            end
        end else begin
            if (wr_phase) begin
                stop_q <= !mode_q.rpt || hit || last;
            end
            if (slot_q == end_slot) begin
                slot_q <= '0;
                if (stop_q) begin
                    busy <= 1'b0;
                end
            end else begin
                slot_q <= slot_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/blkmv_cmp.sv
module blkmv_cmp (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_acc,
    input  logic       wr_phase,
    input  logic       srch,
    input  logic [7:0] rdata,
    input  logic [7:0] key,
    output logic       hit,
    output logic       match
);
    assign hit = wr_phase && srch && (rdata == key);

    always_ff @(posedge clk) begin
        if (rst) begin
            match <= 1'b0;
        end else if (start_acc) begin
            match <= 1'b0;
        end else if (hit) begin
            match <= 1'b1;
        end
    end

endmodule

// File: rtl/blkmv_engine.sv
module blkmv_engine
    import blkmv_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int STEP_CYCLES   = 16,
    parameter int REPEAT_CYCLES = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [7:0]        key,
    input  logic              ld_src,
    input  logic              ld_dst,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] ld_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              cnt_nz,
    output logic              match
);
    xfer_mode_t        mode_q;
    logic              start_acc;
    logic              rd_phase;
    logic              wr_phase;
    logic              hit;
    logic              last;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [NUM_PTR-1:0] ld_ptr;

    assign start_acc = start && !busy;

    always_comb begin
        ld_ptr          = '0;
        ld_ptr[PTR_SRC] = ld_src;
        ld_ptr[PTR_DST] = ld_dst;
    end

    blkmv_seq #(
        .STEP_CYCLES  (STEP_CYCLES),
        .REPEAT_CYCLES(REPEAT_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_acc(start_acc),
        .mode_in  (xfer_mode_t'(mode)),
        .hit      (hit),
        .last     (last),
        .busy     (busy),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase),
        .mode_q   (mode_q)
    );

    blkmv_regs #(.W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ld_en (!busy),
        .ld_ptr(ld_ptr),
        .ld_cnt(ld_cnt),
        .ld_val(ld_val),
        .adv   (wr_phase && !hit),
        .dec   (mode_q.dec),
        .src   (src),
        .dst   (dst),
        .cnt_nz(cnt_nz),
        .last  (last)
    );

    blkmv_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .start_acc(start_acc),
        .wr_phase (wr_phase),
        .srch     (mode_q.srch),
        .rdata    (mem_rdata),
        .key      (key),
        .hit      (hit),
        .match    (match)
    );

    assign mem_rd    = rd_phase;
    assign mem_wr    = wr_phase && !hit;
    assign mem_addr  = wr_phase ? dst : src;
    assign mem_wdata = mem_rdata;

endmodule

// File: rtl/blkmv_chk.sv
module blkmv_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic mem_rd,
    input logic mem_wr,
    input logic cnt_nz,
    input logic match
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R1
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst) mem_wr |-> $past(mem_rd)); // R1
    AST_NZ_MOVES_ON_WR: assert property (@(posedge clk) disable iff (rst) !$stable(cnt_nz) |-> $past(mem_wr)); // R5
    AST_MATCH_NO_WR: assert property (@(posedge clk) disable iff (rst) $rose(match) |-> !$past(mem_wr)); // R8
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start)); // R9
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst) !busy |-> !(mem_rd || mem_wr)); // R9
endmodule

bind blkmv_engine blkmv_chk u_chk (.*);

// File: tb/tb_blkmv_engine.sv
module tb_blkmv_engine;
    localparam int AW = 8;
    localparam int N  = 1 << AW;
    localparam int CS = 16;
    localparam int CR = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [7:0]    key = '0;
    logic          ld_src = 1'b0, ld_dst = 1'b0, ld_cnt = 1'b0;
    logic [AW-1:0] ld_val = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          busy, cnt_nz, match;

    int nchk = 0;
    int nfail = 0;

    logic [7:0] mem [N];
    logic [7:0] ref_m [N];
    logic       init_req = 1'b0;
    logic [7:0] init_seed = '0;
    logic [AW-1:0] m_src = '0, m_dst = '0, m_cnt = '0;
    logic m_nz = 1'b0, m_match = 1'b0;

    always #10 clk = ~clk;

    blkmv_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .key(key),
        .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .ld_val(ld_val),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .cnt_nz(cnt_nz), .match(match)
    );

    function automatic logic [7:0] pat(input int i, input logic [7:0] s);
        return 8'((i * 29) + (int'(s) * 7) + (i >> 3));
    endfunction

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < N; i++) mem[i] <= pat(i, init_seed);
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr];
            if (mem_wr) mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] s);
        @(negedge clk); init_seed = s; init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
        for (int i = 0; i < N; i++) ref_m[i] = pat(i, s);
    endtask

    task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [AW-1:0] c);
        @(negedge clk);
        ld_src = 1'b1; ld_dst = 1'b1; ld_cnt = 1'b1; ld_val = s;
        @(negedge clk); ld_src = 1'b0; ld_cnt = 1'b0; ld_val = d;
        @(negedge clk); ld_dst = 1'b0; ld_cnt = 1'b1; ld_val = c;
        @(negedge clk); ld_cnt = 1'b0;
        m_src = s; m_dst = d; m_cnt = c;
    endtask

    // independent reference: returns number of byte slots used
    function automatic int model(input logic [2:0] md, input logic [7:0] k);
        int slots = 0;
        m_match = 1'b0;
        forever begin
            slots++;
            if (md[0] && ref_m[m_src] == k) begin
                m_match = 1'b1;
                break;
            end
            ref_m[m_dst] = ref_m[m_src];
            m_src = md[1] ? m_src - 1'b1 : m_src + 1'b1;
            m_dst = md[1] ? m_dst - 1'b1 : m_dst + 1'b1;
            m_cnt = m_cnt - 1'b1;
            m_nz  = (m_cnt != 0);
            if (!md[2] || m_cnt == 0) break;
        end
        return slots;
    endfunction

    task automatic run(input logic [2:0] md, input logic [7:0] k, input bit poke, input string tag);
        int cyc = 0;
        int exp_cyc;
        int bad = 0;
        exp_cyc = model(md, k) * (md[2] ? CR : CS);
        @(negedge clk); start = 1'b1; mode = md; key = k;
        @(negedge clk); start = 1'b0;
        while (busy && cyc < 20000) begin
            cyc++;
            if (poke && cyc == 5) begin
                start = 1'b1; mode = 3'b110;
                ld_src = 1'b1; ld_dst = 1'b1; ld_cnt = 1'b1; ld_val = 8'h55;
            end else begin
                start = 1'b0; ld_src = 1'b0; ld_dst = 1'b0; ld_cnt = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; ld_src = 1'b0; ld_dst = 1'b0; ld_cnt = 1'b0;
        chk(cyc == exp_cyc, {tag, " R3 busy cycles"}, cyc, exp_cyc);
        chk(cnt_nz == m_nz, {tag, " R5 cnt_nz"}, int'(cnt_nz), int'(m_nz));
        chk(match == m_match, {tag, " R8 match"}, int'(match), int'(m_match));
        for (int i = 0; i < N; i++) if (mem[i] !== ref_m[i]) bad++;
        chk(bad == 0, {tag, " R1 memory image mismatches"}, bad, 0);
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !cnt_nz && !match, "R10 flags in reset", {busy, cnt_nz, match}, 0);
        chk(!mem_rd && !mem_wr, "R10 no access in reset", {mem_rd, mem_wr}, 0);
        rst = 1'b0;
        fill(8'h11);
        @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr, "R10 idle after reset", {busy, mem_rd, mem_wr}, 0);

        // R1 R2 single step, upward
        load(8'h10, 8'h40, 8'h03);
        run(3'b000, 8'h00, 1'b0, "R1 single");
        // R5 single step reaching zero
        load(8'h20, 8'h60, 8'h01);
        run(3'b000, 8'h00, 1'b0, "R5 single last");
        // R2 repeat upward
        load(8'h05, 8'h90, 8'd10);
        run(3'b100, 8'h00, 1'b0, "R2 repeat up");
        // R4 repeat downward
        load(8'h3F, 8'hC0, 8'd9);
        run(3'b110, 8'h00, 1'b0, "R4 repeat down");
        // R7 wrap upward and downward
        load(8'hFC, 8'hA0, 8'd8);
        run(3'b100, 8'h00, 1'b0, "R7 wrap up");
        load(8'h02, 8'h70, 8'd7);
        run(3'b110, 8'h00, 1'b0, "R7 wrap down");
        // R8 search hit at offset 5, then no-hit, then clear
        fill(8'h23);
        load(8'h30, 8'hB0, 8'd12);
        run(3'b101, ref_m[8'h35], 1'b0, "R8 search hit");
        run(3'b000, 8'h00, 1'b0, "R8 match cleared");
        load(8'h00, 8'h80, 8'd4);
        run(3'b101, 8'hFF, 1'b0, "R8 search miss");
        // R9 start and loads ignored while busy, follow-up without reload
        load(8'h48, 8'hD0, 8'd4);
        run(3'b100, 8'h00, 1'b1, "R9 busy poke");
        run(3'b000, 8'h00, 1'b0, "R9 state kept");
        // R6 zero count repeats over the full range
        fill(8'h37);
        load(8'h00, 8'h80, 8'h00);
        run(3'b100, 8'h00, 1'b0, "R6 zero count");
        // sweep over direction, repeat and length (R2 R4)
        for (int r = 0; r < 2; r++) begin
            for (int d = 0; d < 2; d++) begin
                for (int n = 1; n <= 12; n++) begin
                    load(AW'(n * 13), AW'(8'h80 + n * 7), AW'(n));
                    run({r[0], d[0], 1'b0}, 8'h00, 1'b0, "R2 R4 sweep");
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule